// File: doc/BRIEF.md
# BCD Seven-Segment Digit Decoder with Blanking Controls

This block converts one 4-bit BCD digit into seven active-low segment drives, ordered a (top), b, c, d (bottom), e, f, g (middle). It is purely combinational. Three active-low controls shape the output. The first is a lamp test that lights every segment. The second is a forced blank that darkens the digit. The third is a ripple-blank input that darkens the digit only when the digit is zero.

A ripple-blank output lets several decoders form a chain for leading-zero suppression. The most significant stage has its ripple-blank input tied low. Each stage's ripple-blank output feeds the ripple-blank input of the next less significant stage. Each zero digit then stays dark until the first nonzero digit appears. The forced-blank input and the ripple-blank output are separate ports.

Top module: `seg_digit_decoder`

## Requirements
- R1: With all controls high (inactive), codes 0 to 9 drive `seg_n` (bit 6 = a down to bit 0 = g, 0 lights a segment) as follows: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=1100000, 7=0001111, 8=0000000, 9=0001100.
- R2: With all controls inactive, codes 10 to 14 drive fixed patterns: 10=1110010, 11=1100110, 12=1011100, 13=0110100, 14=1110000.
- R3: Code 15 with all controls inactive drives 1111111 (all segments dark).
- R4: When `lamp_test_n` is low and `blank_n` is high, `seg_n` is 0000000 for every digit code and every ripple-blank input level.
- R5: When `blank_n` is low, `seg_n` is 1111111 for every digit code and every level of the other two controls. This input outranks lamp test.
- R6: When `ripple_blank_in_n` is low, the digit is 0 and both other controls are high, `seg_n` is 1111111.
- R7: When `ripple_blank_in_n` is low and the digit is nonzero, with both other controls high, `seg_n` shows the same pattern as in R1/R2/R3.
- R8: `ripple_blank_out_n` is 0 exactly when `ripple_blank_in_n` is 0, the digit is 0 and `lamp_test_n` is 1. It is 1 in every other case.
- R9: `ripple_blank_out_n` does not depend on `blank_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_i | input | 4 | BCD digit code |
| lamp_test_n | input | 1 | Active-low lamp test: lights all segments |
| ripple_blank_in_n | input | 1 | Active-low zero suppression from the more significant stage |
| blank_n | input | 1 | Active-low forced blank of the whole digit |
| seg_n | output | 7 | Active-low segment drives, bit 6 = a down to bit 0 = g |
| ripple_blank_out_n | output | 1 | Active-low zero-suppression request to the next less significant stage |

## Verification
The bench applies all 16 digit codes under all eight combinations of the three controls. This covers every priority collision. If forced blank lost to lamp test, a fully lit digit would appear where a dark one is expected. If the ripple-blank test checked only the control and not the zero digit, nonzero digits under suppression would vanish. If the ripple-blank output ignored lamp test or followed the forced blank, the chain would suppress the wrong digits. Glyphs 6, 7 and 9 and the codes 10 to 15 are compared bit for bit, which exposes a swapped segment order or a missing tail segment.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef logic [SEG_W-1:0]   seg_t;
    typedef logic [DIGIT_W-1:0] digit_t;

    localparam seg_t SEG_ALL_DARK = {SEG_W{1'b1}};
    localparam seg_t SEG_ALL_LIT  = {SEG_W{1'b0}};

    typedef enum logic [1:0] {
        SRC_GLYPH = 2'd0,
        SRC_DARK  = 2'd1,
        SRC_LIT   = 2'd2
    } seg_src_e;

    typedef struct packed {
        seg_src_e src;
        logic     rbo_n;
    } blank_ctl_t;
endpackage

// File: rtl/seg_glyph_table.sv
module seg_glyph_table
    import seg_dec_pkg::*;
(
    input  digit_t code_i,
    output seg_t   glyph_n_o
);
    seg_t glyph_d;

    always_comb begin
        unique case (code_i)
            4'd0:  glyph_d = 7'b0000001;
            4'd1:  glyph_d = 7'b1001111;
            4'd2:  glyph_d = 7'b0010010;
            4'd3:  glyph_d = 7'b0000110;
            4'd4:  glyph_d = 7'b1001100;
            4'd5:  glyph_d = 7'b0100100;
            4'd6:  glyph_d = 7'b1100000;
            4'd7:  glyph_d = 7'b0001111;
            4'd8:  glyph_d = 7'b0000000;
            4'd9:  glyph_d = 7'b0001100;
            4'd10: glyph_d = 7'b1110010;
            4'd11: glyph_d = 7'b1100110;
            4'd12: glyph_d = 7'b1011100;
            4'd13: glyph_d = 7'b0110100;
            4'd14: glyph_d = 7'b1110000;
            default: glyph_d = SEG_ALL_DARK;
        endcase
    end

    assign glyph_n_o = glyph_d;
endmodule

// File: rtl/seg_blank_ctrl.sv
module seg_blank_ctrl
    import seg_dec_pkg::*;
(
    input  digit_t     code_i,
    input  logic       lamp_test_n,
    input  logic       ripple_blank_in_n,
    input  logic       blank_n,
    output blank_ctl_t ctl_o
);
    blank_ctl_t ctl_d;
    logic       is_zero;

    assign is_zero = (code_i == '0);

    always_comb begin
        ctl_d       = '{src: SRC_GLYPH, rbo_n: 1'b1};
        // Suppression request travels on regardless of forced blank.
        ctl_d.rbo_n = ~(~ripple_blank_in_n & is_zero & lamp_test_n);
        if (!blank_n) begin
            ctl_d.src = SRC_DARK;
        end else if (!lamp_test_n) begin
            ctl_d.src = SRC_LIT;
        end else if (!ripple_blank_in_n && is_zero) begin
            ctl_d.src = SRC_DARK;
        end
    end

    assign ctl_o = ctl_d;
endmodule

// File: rtl/seg_digit_decoder.sv
module seg_digit_decoder
    import seg_dec_pkg::*;
(
    input  logic [3:0] digit_i,
    input  logic       lamp_test_n,
    input  logic       ripple_blank_in_n,
    input  logic       blank_n,
    output logic [6:0] seg_n,
    output logic       ripple_blank_out_n
);
    seg_t       glyph_n;
    blank_ctl_t ctl;
    seg_t       seg_d;

    seg_glyph_table u_glyph (
        .code_i    (digit_i),
        .glyph_n_o (glyph_n)
    );

    seg_blank_ctrl u_ctrl (
        .code_i            (digit_i),
        .lamp_test_n       (lamp_test_n),
        .ripple_blank_in_n (ripple_blank_in_n),
        .blank_n           (blank_n),
        .ctl_o             (ctl)
    );

    always_comb begin
        unique case (ctl.src)
            SRC_DARK: seg_d = SEG_ALL_DARK;
            SRC_LIT:  seg_d = SEG_ALL_LIT;
            default:  seg_d = glyph_n;
        endcase
    end

    assign seg_n              = seg_d;
    assign ripple_blank_out_n = ctl.rbo_n;

    always_comb begin
        if (!blank_n) begin
            assert_blank_dark_R5: assert (seg_n == SEG_ALL_DARK);
        end
        if (blank_n && !lamp_test_n) begin
            assert_lamp_lit_R4: assert (seg_n == SEG_ALL_LIT);
        end
        if (blank_n && lamp_test_n && !ripple_blank_in_n && digit_i == '0) begin
            assert_zero_dark_R6: assert (seg_n == SEG_ALL_DARK);
        end
        if (!ripple_blank_out_n) begin
            assert_rbo_cause_R8: assert (digit_i == '0 && !ripple_blank_in_n && lamp_test_n);
        end
        if (blank_n && lamp_test_n && digit_i == 4'd8) begin
            assert_eight_full_R1: assert (seg_n == SEG_ALL_LIT);
        end
    end
endmodule

// File: tb/seg_digit_decoder_test.sv
module seg_digit_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] digit_i = '0;
    logic       lamp_test_n = 1'b1;
    logic       ripple_blank_in_n = 1'b1;
    logic       blank_n = 1'b1;
    logic [6:0] seg_n;
    logic       ripple_blank_out_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [6:0] seg;
        logic       rbo;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_digit_decoder uut (
        .digit_i            (digit_i),
        .lamp_test_n        (lamp_test_n),
        .ripple_blank_in_n  (ripple_blank_in_n),
        .blank_n            (blank_n),
        .seg_n              (seg_n),
        .ripple_blank_out_n (ripple_blank_out_n)
    );

    function automatic logic [6:0] glyph(input logic [3:0] c);
        logic [6:0] t [16];
        t[0]=7'b0000001; t[1]=7'b1001111; t[2]=7'b0010010; t[3]=7'b0000110;
        t[4]=7'b1001100; t[5]=7'b0100100; t[6]=7'b1100000; t[7]=7'b0001111;
        t[8]=7'b0000000; t[9]=7'b0001100; t[10]=7'b1110010; t[11]=7'b1100110;
        t[12]=7'b1011100; t[13]=7'b0110100; t[14]=7'b1110000; t[15]=7'b1111111;
        return t[c];
    endfunction

    task automatic drive(input logic [3:0] d, input logic lt, input logic rbi, input logic bl);
        exp_t e;
        @(posedge clk);
        digit_i = d; lamp_test_n = lt; ripple_blank_in_n = rbi; blank_n = bl;
        if (!bl) begin
            e.seg = 7'h7F; e.req = "R5";
        end else if (!lt) begin
            e.seg = 7'h00; e.req = "R4";
        end else if (!rbi && d == 0) begin
            e.seg = 7'h7F; e.req = "R6";
        end else begin
            e.seg = glyph(d);
            e.req = !rbi ? "R7" : (d == 15 ? "R3" : (d > 9 ? "R2" : "R1"));
        end
        e.rbo = (!rbi && d == 0 && lt) ? 1'b0 : 1'b1;
        sb.push_back(e);
    endtask

    // monitor: samples at the falling edge, half a period after inputs move
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (seg_n !== e.seg) begin
                fails++;
                $display("FAIL %s seg_n actual=%b expected=%b (digit=%0d lt=%b rbi=%b bl=%b)",
                         e.req, seg_n, e.seg, digit_i, lamp_test_n, ripple_blank_in_n, blank_n);
            end
            checks++;
            if (ripple_blank_out_n !== e.rbo) begin
                fails++;
                $display("FAIL %s ripple_blank_out_n actual=%b expected=%b (digit=%0d lt=%b rbi=%b bl=%b)",
                         (blank_n ? "R8" : "R9"), ripple_blank_out_n, e.rbo,
                         digit_i, lamp_test_n, ripple_blank_in_n, blank_n);
            end
        end
    end

    initial begin
        // idle state check: controls inactive, digit 0 shows glyph 0 (R1)
        drive(4'd0, 1'b1, 1'b1, 1'b1);
        // R1/R2/R3 normal decoding sweep
        for (int d = 0; d < 16; d++) drive(4'(d), 1'b1, 1'b1, 1'b1);
        // R4..R9: every control combination against every code
        for (int c = 0; c < 8; c++) begin
            for (int d = 0; d < 16; d++) begin
                drive(4'(d), c[2], c[1], c[0]);
            end
        end
        // R9 focus: same zero-suppress case with forced blank toggled
        drive(4'd0, 1'b1, 1'b0, 1'b0);
        drive(4'd0, 1'b1, 1'b0, 1'b1);
        // R6/R7 boundary: zero then one under suppression
        drive(4'd0, 1'b1, 1'b0, 1'b1);
        drive(4'd1, 1'b1, 1'b0, 1'b1);
        @(posedge clk);
        @(posedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule